// File: doc/BRIEF.md
# Load/Store Queue with Store-to-Load Forwarding

This block sits beside an out-of-order core and holds every memory operation that is in flight, in program order, in a circular queue of configurable depth (twelve entries by default). Each entry records whether it is a load or a store. It also records an address that is either known or still waiting on a producer tag, and, for a store, a data value that is likewise known or pending. A result broadcast fills in whichever pending fields carry the broadcast tag.

A load may only proceed once its own address is known and every older store in the queue has a known address. If one or more of those older stores write the same address, the load takes its value from the youngest of them, or waits if that value is not ready yet. With no match, the load reads the data cache through a single request port and receives the data a fixed number of cycles later. Stores are speculative until the core retires them. Only retired stores at the head of the queue write the cache, one per cycle, and they take precedence over load probes. A flush drops every entry that has not retired, and any cache read still outstanding for a flushed load. Retired stores survive the flush and still drain.

Top module: `lsq_buffer`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, and `creq_valid` and `ld_valid` are 0.
- R2: The queue accepts at most DEPTH entries. `alloc_ready` is 0 while all DEPTH entries are occupied, and an allocation presented while it is 0 has no effect: that operation never reaches the cache.
- R3: A pending address or pending store data is replaced by `bc_value` when a broadcast carries the matching tag in a cycle after the entry was allocated.
- R4: A load whose address equals that of an older store with ready data gets that store's data on `ld_data` with its own `ld_tag`, and no cache read is made. `ld_valid` is asserted the cycle after the first cycle in which the load sits in the queue and is eligible.
- R5: When several older stores match a load, the value comes from the youngest of them. Stores younger than the load are ignored.
- R6: A load waits, with no result and no cache read, while any older store has an unknown address, or while its youngest matching older store has no data yet.
- R7: A load with no older matching store issues a cache read (`creq_valid`=1, `creq_write`=0). Its result appears on `ld_valid`/`ld_data` LD_LAT+1 cycles after the request cycle, carrying the `crsp_data` value from LD_LAT cycles after the request.
- R8: A store writes the cache (`creq_write`=1) only after it has been retired, and stores write in program order.
- R9: `flush` removes every entry not yet retired, including a retire given in the same cycle as retired. No result is returned for a flushed load, even when its cache read was already sent. Retired stores still write the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a new entry at the tail |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_addr_rdy | input | 1 | Address is known at allocation |
| alloc_addr | input | ADDR_W | Address when known |
| alloc_addr_tag | input | TAG_W | Producer tag of a pending address |
| alloc_data_rdy | input | 1 | Store data is known at allocation |
| alloc_data | input | DATA_W | Store data when known |
| alloc_data_tag | input | TAG_W | Producer tag of pending store data |
| alloc_ld_tag | input | TAG_W | Destination tag returned with a load result |
| alloc_ready | output | 1 | Queue has a free entry |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_value | input | DATA_W | Broadcast value (low ADDR_W bits used for addresses) |
| retire_valid | input | 1 | Retire the oldest unretired entry |
| flush | input | 1 | Drop all unretired entries |
| creq_valid | output | 1 | Cache request valid |
| creq_write | output | 1 | 1 = store write, 0 = load read |
| creq_addr | output | ADDR_W | Cache request address |
| creq_wdata | output | DATA_W | Store write data |
| crsp_data | input | DATA_W | Read data, LD_LAT cycles after a read request |
| ld_valid | output | 1 | Load result valid |
| ld_tag | output | TAG_W | Destination tag of the load result |
| ld_data | output | DATA_W | Load result value |

## Verification
A forwarded result is due on the second falling edge after the load is allocated: one edge to write the entry and one to register the result. A cache read is due LD_LAT+1 cycles after its request. The bench stamps every request and result with a cycle counter on the falling edge and compares the gaps with these figures. Stalls, flushes and store drains are judged over windows much longer than these latencies, so an absent result or write is only reported once it can no longer arrive. The bench's cache model returns read data exactly LD_LAT cycles after the request.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam logic OP_LOAD  = 1'b0;
  localparam logic OP_STORE = 1'b1;

  // position `off` steps after `base` in a ring of `depth` slots
  function automatic int ring_idx(input int base, input int off, input int depth);
    int s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/lsq_select.sv
module lsq_select #(
  parameter int DEPTH  = 12,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [PW-1:0]     head,
  input  logic [CW-1:0]     count,
  input  logic              v     [DEPTH],
  input  logic              is_st [DEPTH],
  input  logic              a_rdy [DEPTH],
  input  logic              d_rdy [DEPTH],
  input  logic              done  [DEPTH],
  input  logic [ADDR_W-1:0] addr  [DEPTH],
  input  logic [DATA_W-1:0] data  [DEPTH],
  output logic              sel_valid,
  output logic              sel_fwd,
  output logic [PW-1:0]     sel_idx,
  output logic [DATA_W-1:0] sel_data
);
  // Oldest load that may proceed: every older store address is known and the
  // youngest older store on the same address (if any) has its data.
  always_comb begin
    logic [PW-1:0]     ik, jk;
    logic              blk, hit, hit_rdy;
    logic [DATA_W-1:0] hit_d;
    sel_valid = 1'b0;
    sel_fwd   = 1'b0;
    sel_idx   = '0;
    sel_data  = '0;
    ik = '0; jk = '0; blk = 1'b0; hit = 1'b0; hit_rdy = 1'b0; hit_d = '0;
    for (int k = 0; k < DEPTH; k++) begin
      ik = PW'(lsq_pkg::ring_idx(int'(head), k, DEPTH));
      if (!sel_valid && k < int'(count) && v[ik] && is_st[ik] == lsq_pkg::OP_LOAD
          && a_rdy[ik] && !done[ik]) begin
        blk = 1'b0; hit = 1'b0; hit_rdy = 1'b0; hit_d = '0;
        for (int j = 0; j < DEPTH; j++) begin
          jk = PW'(lsq_pkg::ring_idx(int'(head), j, DEPTH));
          if (j < k && v[jk] && is_st[jk] == lsq_pkg::OP_STORE) begin
            if (!a_rdy[jk]) blk = 1'b1;
            else if (addr[jk] == addr[ik]) begin
              hit = 1'b1; hit_rdy = d_rdy[jk]; hit_d = data[jk];
            end
          end
        end
        if (!blk && (!hit || hit_rdy)) begin
          sel_valid = 1'b1;
          sel_fwd   = hit;
          sel_idx   = ik;
          sel_data  = hit_d;
        end
      end
    end
  end
endmodule

// File: rtl/lsq_loadpipe.sv
module lsq_loadpipe #(
  parameter int LAT   = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  output logic             out_v,
  output logic [TAG_W-1:0] out_tag
);
  logic             stg_v   [LAT];
  logic [TAG_W-1:0] stg_tag [LAT];

  always_ff @(posedge clk) begin
    stg_v[0]   <= (rst || flush) ? 1'b0 : push;
    stg_tag[0] <= push_tag;
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stg_v[s]   <= (rst || flush) ? 1'b0 : stg_v[s-1];
      stg_tag[s] <= stg_tag[s-1];
    end
  end

  assign out_v   = stg_v[LAT-1];
  assign out_tag = stg_tag[LAT-1];
endmodule

// File: rtl/lsq_buffer.sv
module lsq_buffer #(
  parameter int DEPTH  = 12,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 5,
  parameter int LD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic              alloc_is_store,
  input  logic              alloc_addr_rdy,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [TAG_W-1:0]  alloc_addr_tag,
  input  logic              alloc_data_rdy,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic [TAG_W-1:0]  alloc_data_tag,
  input  logic [TAG_W-1:0]  alloc_ld_tag,
  output logic              alloc_ready,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  input  logic              retire_valid,
  input  logic              flush,
  output logic              creq_valid,
  output logic              creq_write,
  output logic [ADDR_W-1:0] creq_addr,
  output logic [DATA_W-1:0] creq_wdata,
  input  logic [DATA_W-1:0] crsp_data,
  output logic              ld_valid,
  output logic [TAG_W-1:0]  ld_tag,
  output logic [DATA_W-1:0] ld_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic              v_q    [DEPTH];
  logic              st_q   [DEPTH];
  logic              ar_q   [DEPTH];
  logic              dr_q   [DEPTH];
  logic              done_q [DEPTH];
  logic              ret_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [TAG_W-1:0]  at_q   [DEPTH];
  logic [TAG_W-1:0]  dt_q   [DEPTH];
  logic [TAG_W-1:0]  lt_q   [DEPTH];

  logic [PW-1:0] head_q, tail, rp;
  logic [CW-1:0] count_q, nret_q, cnt_n, nret_n;
  logic          sel_valid, sel_fwd;
  logic [PW-1:0] sel_idx;
  logic [DATA_W-1:0] sel_data;
  logic          drain, do_probe, do_fwd, deq, ret_fire, do_alloc;
  logic          pipe_v;
  logic [TAG_W-1:0] pipe_tag, creq_tag;

  lsq_select #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
    .head(head_q), .count(count_q), .v(v_q), .is_st(st_q), .a_rdy(ar_q),
    .d_rdy(dr_q), .done(done_q), .addr(addr_q), .data(data_q),
    .sel_valid(sel_valid), .sel_fwd(sel_fwd), .sel_idx(sel_idx), .sel_data(sel_data)
  );

  lsq_loadpipe #(.LAT(LD_LAT), .TAG_W(TAG_W)) u_pipe (
    .clk(clk), .rst(rst), .flush(flush),
    .push(creq_valid && !creq_write), .push_tag(creq_tag),
    .out_v(pipe_v), .out_tag(pipe_tag)
  );

  assign tail        = PW'(lsq_pkg::ring_idx(int'(head_q), int'(count_q), DEPTH));
  assign rp          = PW'(lsq_pkg::ring_idx(int'(head_q), int'(nret_q), DEPTH));
  assign alloc_ready = (count_q < CW'(DEPTH));
  assign do_alloc    = alloc_valid && alloc_ready && !flush;
  assign ret_fire    = retire_valid && (nret_q < count_q);
  // retired store at the head owns the cache port
  assign drain       = (count_q != '0) && v_q[head_q] && ret_q[head_q]
                       && st_q[head_q] && dr_q[head_q];
  assign deq         = (count_q != '0) && v_q[head_q] && ret_q[head_q]
                       && (!st_q[head_q] || drain);
  assign do_probe    = sel_valid && !sel_fwd && !drain && !flush;
  assign do_fwd      = sel_valid && sel_fwd && !pipe_v && !flush;

  always_comb begin
    cnt_n  = count_q + CW'(do_alloc) - CW'(deq);
    nret_n = nret_q + CW'(ret_fire) - CW'(deq);
    if (flush) cnt_n = nret_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      count_q <= '0;
      nret_q  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        v_q[i]   <= 1'b0;
        ret_q[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (bc_valid && v_q[i]) begin
          if (!ar_q[i] && at_q[i] == bc_tag) begin
            ar_q[i]   <= 1'b1;
            addr_q[i] <= bc_value[ADDR_W-1:0];
          end
          if (st_q[i] && !dr_q[i] && dt_q[i] == bc_tag) begin
            dr_q[i]   <= 1'b1;
            data_q[i] <= bc_value;
          end
        end
        if (flush && !(ret_q[i] || (ret_fire && PW'(i) == rp))) v_q[i] <= 1'b0;
      end
      if (do_fwd || do_probe) done_q[sel_idx] <= 1'b1;
      if (ret_fire) ret_q[rp] <= 1'b1;
      if (deq) begin
        v_q[head_q] <= 1'b0;
        head_q      <= PW'(lsq_pkg::ring_idx(int'(head_q), 1, DEPTH));
      end
      if (do_alloc) begin
        v_q[tail]    <= 1'b1;
        st_q[tail]   <= alloc_is_store;
        ar_q[tail]   <= alloc_addr_rdy;
        addr_q[tail] <= alloc_addr;
        at_q[tail]   <= alloc_addr_tag;
        dr_q[tail]   <= alloc_data_rdy;
        data_q[tail] <= alloc_data;
        dt_q[tail]   <= alloc_data_tag;
        lt_q[tail]   <= alloc_ld_tag;
        done_q[tail] <= 1'b0;
        ret_q[tail]  <= 1'b0;
      end
      count_q <= cnt_n;
      nret_q  <= nret_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      creq_valid <= 1'b0;
      creq_write <= 1'b0;
      ld_valid   <= 1'b0;
    end else begin
      creq_valid <= drain || do_probe;
      creq_write <= drain;
      ld_valid   <= !flush && (do_fwd || pipe_v);
    end
    creq_addr  <= drain ? addr_q[head_q] : addr_q[sel_idx];
    creq_wdata <= data_q[head_q];
    creq_tag   <= lt_q[sel_idx];
    ld_tag     <= do_fwd ? lt_q[sel_idx] : pipe_tag;
    ld_data    <= do_fwd ? sel_data : crsp_data;
  end
endmodule

// File: rtl/lsq_buffer_chk.sv
module lsq_buffer_chk #(
  parameter int DEPTH = 12,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          retire_valid,
  input logic          flush,
  input logic          creq_valid,
  input logic          creq_write,
  input logic [15:0]   creq_addr_lo,
  input logic          ld_valid,
  input logic [CW-1:0] count_q
);
  logic [31:0] n_ret, n_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_ret <= '0;
      n_wr  <= '0;
    end else begin
      n_ret <= n_ret + 32'(retire_valid);
      n_wr  <= n_wr + 32'(creq_valid && creq_write);
    end
  end

  // R2: occupancy never exceeds the configured depth
  p_cap_r2: assert property (@(posedge clk) disable iff (rst)
    int'(count_q) <= DEPTH);

  // R8: cache writes never outnumber retirements
  p_wr_after_ret_r8: assert property (@(posedge clk) disable iff (rst)
    n_wr <= n_ret);

  // R9: no load result in the cycle after a flush
  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !ld_valid);

  // R7: every cache request carries a defined address
  p_req_known_r7: assert property (@(posedge clk) disable iff (rst)
    creq_valid |-> !$isunknown(creq_addr_lo));
endmodule

bind lsq_buffer lsq_buffer_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH + 1))) u_chk (
  .clk(clk), .rst(rst), .retire_valid(retire_valid), .flush(flush),
  .creq_valid(creq_valid), .creq_write(creq_write),
  .creq_addr_lo(16'(creq_addr)), .ld_valid(ld_valid), .count_q(count_q)
);

// File: tb/lsq_buffer_test.sv
module lsq_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 12, AW = 16, DW = 16, TW = 5, LD_LAT = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_valid = 0, alloc_is_store = 0, alloc_addr_rdy = 0, alloc_data_rdy = 0;
  logic [AW-1:0] alloc_addr = '0;
  logic [DW-1:0] alloc_data = '0, bc_value = '0, crsp_data;
  logic [TW-1:0] alloc_addr_tag = '0, alloc_data_tag = '0, alloc_ld_tag = '0, bc_tag = '0;
  logic bc_valid = 0, retire_valid = 0, flush = 0, alloc_ready;
  logic creq_valid, creq_write, ld_valid;
  logic [AW-1:0] creq_addr;
  logic [DW-1:0] creq_wdata, ld_data;
  logic [TW-1:0] ld_tag;

  lsq_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .LD_LAT(LD_LAT)) uut (
    .clk, .rst, .alloc_valid, .alloc_is_store, .alloc_addr_rdy, .alloc_addr,
    .alloc_addr_tag, .alloc_data_rdy, .alloc_data, .alloc_data_tag, .alloc_ld_tag,
    .alloc_ready, .bc_valid, .bc_tag, .bc_value, .retire_valid, .flush,
    .creq_valid, .creq_write, .creq_addr, .creq_wdata, .crsp_data,
    .ld_valid, .ld_tag, .ld_data);

  always #(CLK_PERIOD/2) clk = ~clk;

  // cache model with fixed read latency
  function automatic logic [15:0] fmem(input logic [7:0] a);
    return {a, ~a};
  endfunction
  logic [DW-1:0] mem [256];
  logic [DW-1:0] rdq [LD_LAT];
  initial for (int i = 0; i < 256; i++) mem[i] = fmem(8'(i));
  always @(posedge clk) begin
    if (creq_valid && creq_write) mem[creq_addr[7:0]] <= creq_wdata;
    rdq[0] <= (creq_valid && !creq_write) ? mem[creq_addr[7:0]] : '0;
    for (int s = 1; s < LD_LAT; s++) rdq[s] <= rdq[s-1];
  end
  assign crsp_data = rdq[LD_LAT-1];

  // monitor
  int cyc = 0, n_ld = 0, n_rd = 0, n_wr = 0, ld_cyc = 0, rd_cyc = 0, alloc_cyc = 0;
  logic [DW-1:0] last_ld, last_wd;
  logic [AW-1:0] last_wa;
  logic [TW-1:0] last_tag;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!rst) begin
    if (ld_valid) begin n_ld++; last_ld = ld_data; last_tag = ld_tag; ld_cyc = cyc; end
    if (creq_valid && creq_write) begin n_wr++; last_wa = creq_addr; last_wd = creq_wdata; end
    if (creq_valid && !creq_write) begin n_rd++; rd_cyc = cyc; end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    alloc_valid = 0; retire_valid = 0; flush = 0; bc_valid = 0;
  endtask
  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); clr(); end
  endtask
  task automatic st(input bit ar, input logic [15:0] a, input logic [4:0] at,
                    input bit dr, input logic [15:0] d, input logic [4:0] dt);
    @(negedge clk); clr();
    alloc_valid = 1; alloc_is_store = 1; alloc_addr_rdy = ar; alloc_addr = a;
    alloc_addr_tag = at; alloc_data_rdy = dr; alloc_data = d; alloc_data_tag = dt;
  endtask
  task automatic ld(input logic [15:0] a, input logic [4:0] tag);
    @(negedge clk); clr();
    alloc_valid = 1; alloc_is_store = 0; alloc_addr_rdy = 1; alloc_addr = a;
    alloc_ld_tag = tag; alloc_cyc = cyc;
  endtask
  task automatic ret(input int n);
    repeat (n) begin @(negedge clk); clr(); retire_valid = 1; end
  endtask
  task automatic bc(input logic [4:0] tag, input logic [15:0] val);
    @(negedge clk); clr(); bc_valid = 1; bc_tag = tag; bc_value = val;
  endtask

  // rows: store address, store data, load address
  localparam logic [47:0] TBL [6] = '{
    {16'h0010, 16'h1111, 16'h0010}, {16'h0020, 16'h2222, 16'h0021},
    {16'h0030, 16'hBEEF, 16'h0030}, {16'h0040, 16'h4444, 16'h0004},
    {16'h0050, 16'h0000, 16'h0050}, {16'h0060, 16'h6666, 16'h0061}};

  initial begin
    int l0, r0, w0;
    repeat (3) @(negedge clk);
    rst = 0;
    tick(1);
    // R1
    chk(alloc_ready == 1, "R1 alloc_ready after reset", alloc_ready, 1);
    chk(creq_valid == 0 && ld_valid == 0, "R1 idle outputs after reset",
        {creq_valid, ld_valid}, 0);

    // R4 / R7 table
    for (int r = 0; r < 6; r++) begin
      logic [15:0] sa, sd, la, ev;
      bit fwd;
      sa = TBL[r][47:32]; sd = TBL[r][31:16]; la = TBL[r][15:0];
      fwd = (sa == la);
      ev = fwd ? sd : fmem(la[7:0]);
      l0 = n_ld; r0 = n_rd; w0 = n_wr;
      st(1, sa, 0, 1, sd, 0);
      ld(la, 5'(r + 1));
      tick(10);
      chk(n_ld == l0 + 1 && last_ld == ev, fwd ? "R4 forwarded value" : "R7 cache value",
          last_ld, ev);
      chk(last_tag == 5'(r + 1), "R4 result tag", last_tag, r + 1);
      if (fwd) begin
        chk(n_rd == r0, "R4 no cache read on forward", n_rd - r0, 0);
        chk(ld_cyc - alloc_cyc == 2, "R4 forward latency", ld_cyc - alloc_cyc, 2);
      end else begin
        chk(n_rd == r0 + 1, "R7 one cache read", n_rd - r0, 1);
        chk(ld_cyc - rd_cyc == LD_LAT + 1, "R7 read latency", ld_cyc - rd_cyc, LD_LAT + 1);
      end
      chk(n_wr == w0, "R8 no write before retire", n_wr - w0, 0);
      ret(2);
      tick(6);
      chk(n_wr == w0 + 1 && last_wa == sa, "R8 write after retire", last_wa, sa);
    end

    // R5: youngest older matching store wins, younger store ignored
    l0 = n_ld; w0 = n_wr;
    st(1, 16'h0070, 0, 1, 16'h0001, 0);
    st(1, 16'h0070, 0, 1, 16'h0002, 0);
    ld(16'h0070, 5'd9);
    st(1, 16'h0070, 0, 1, 16'h0003, 0);
    tick(8);
    chk(n_ld == l0 + 1 && last_ld == 16'h0002, "R5 youngest older store", last_ld, 2);
    ret(4);
    tick(10);
    chk(n_wr == w0 + 3 && last_wd == 16'h0003, "R8 stores drain in order", last_wd, 3);
    chk(mem[8'h70] == 16'h0003, "R8 final memory value", mem[8'h70], 3);

    // R6 / R3: older store with unknown address blocks the load
    l0 = n_ld; r0 = n_rd;
    st(0, 16'h0000, 5'd3, 1, 16'h5555, 0);
    ld(16'h0080, 5'd10);
    tick(8);
    chk(n_ld == l0 && n_rd == r0, "R6 blocked by unknown store address", n_ld - l0, 0);
    bc(5'd3, 16'h0090);
    tick(10);
    chk(n_ld == l0 + 1 && last_ld == fmem(8'h80), "R3 address resolved, load reads cache",
        last_ld, fmem(8'h80));
    ret(2);
    tick(6);
    chk(last_wa == 16'h0090, "R3 broadcast address used by store", last_wa, 16'h0090);

    // R6 / R3: matching store with pending data stalls, then forwards
    l0 = n_ld; r0 = n_rd;
    st(1, 16'h00A0, 0, 0, 16'h0000, 5'd4);
    ld(16'h00A0, 5'd11);
    tick(8);
    chk(n_ld == l0 && n_rd == r0, "R6 stall on pending store data", n_ld - l0, 0);
    bc(5'd4, 16'h7777);
    tick(6);
    chk(n_ld == l0 + 1 && last_ld == 16'h7777, "R3 forwarded broadcast data", last_ld, 16'h7777);
    chk(n_rd == r0, "R4 forward made no cache read", n_rd - r0, 0);
    ret(2);
    tick(6);

    // R2: capacity and ignored allocation while full
    w0 = n_wr;
    for (int i = 0; i < DEPTH; i++) st(1, 16'(16'h00B0 + i), 0, 1, 16'(16'h0100 + i), 0);
    tick(1);
    chk(alloc_ready == 0, "R2 alloc_ready low when full", alloc_ready, 0);
    st(1, 16'h00CC, 0, 1, 16'hDEAD, 0);
    tick(1);
    ret(DEPTH + 1);
    tick(30);
    chk(n_wr == w0 + DEPTH, "R2 only DEPTH stores written", n_wr - w0, DEPTH);
    chk(mem[8'hCC] == fmem(8'hCC), "R2 allocation while full ignored", mem[8'hCC], fmem(8'hCC));
    chk(alloc_ready == 1, "R2 alloc_ready after drain", alloc_ready, 1);

    // R9: flush with a same-cycle retire and an in-flight load read
    l0 = n_ld; w0 = n_wr;
    st(1, 16'h00D0, 0, 1, 16'hD0D0, 0);
    ld(16'h00D4, 5'd12);
    st(1, 16'h00D8, 0, 1, 16'hD8D8, 0);
    @(negedge clk); clr(); retire_valid = 1; flush = 1;
    tick(12);
    chk(n_ld == l0, "R9 flushed load returns nothing", n_ld - l0, 0);
    chk(n_wr == w0 + 1 && last_wa == 16'h00D0, "R9 retired store still drains", last_wa, 16'h00D0);
    chk(mem[8'hD8] == fmem(8'hD8), "R9 flushed store never written", mem[8'hD8], fmem(8'hD8));
    ld(16'h00D8, 5'd13);
    tick(10);
    chk(n_ld == l0 + 1 && last_tag == 5'd13 && last_ld == fmem(8'hD8),
        "R9 queue usable after flush", last_ld, fmem(8'hD8));
    ret(1);
    tick(4);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule